// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block is an auto-reloading down-counter that raises an interrupt at a fixed period, measured in ticks of a slower source clock. Software programs a reload value and a control word through a small synchronous register port. The control word holds three bits: run, event flag and interrupt enable. Software can read back every register, including the live count. A one-cycle `tick` strobe, produced elsewhere, advances the countdown.

A countdown begins when the run bit goes from 0 to 1. At that moment the counter takes the reload value. Every tick that moves the count from 1 to 0 is an event. An event sets a sticky flag and reloads the counter, so the counter keeps cycling for as long as run stays set. The flag is not tied to the run bit: only an explicit software write of 0 to the flag bit clears it.

The interrupt pin is active-low and open-drain. It is pulled low while both the flag and the interrupt-enable bit are set, and released otherwise. The pin is modelled as a drive enable plus the level seen on the pin with an external pull-up.

Top module: `period_irq_timer`

## Requirements
- R1: After synchronous reset, run, flag and interrupt enable are 0, the count is 0, `irq_drive` is 0 and `irq_level_n` is 1.
- R2: A control write that changes run from 0 to 1 loads the reload value into the count at that clock edge. A control write with run=1 while run is already 1 leaves the count unchanged.
- R3: While run is 0 the count holds its value, whatever `tick` does.
- R4: While run is 1, each cycle with `tick`=1 lowers a nonzero count by 1. A cycle with `tick`=0 leaves the count unchanged.
- R5: A tick that finds the count at 1 is an event. It sets the flag and reloads the count from the reload value, so events repeat every reload-value ticks while run stays 1, including after software has cleared the flag.
- R6: Writing 1 to the flag bit has no effect. Only a control write with the flag bit at 0 clears the flag. Clearing run leaves the flag unchanged.
- R7: `irq_drive` is 1 exactly when both flag and interrupt enable are 1, and it takes effect at the same edge at which either bit changes. `irq_level_n` is always the inverse of `irq_drive`.
- R8: A reload value of 0 never produces an event. The count stays 0 and the flag stays 0.
- R9: When a control write that clears the flag lands in the same cycle as an event, the flag ends up set.
- R10: `rd_data` is registered and shows, one cycle after `rd_addr` is presented, the register it selects:
  - address 0: control, with bit 0 = run, bit 1 = flag, bit 2 = interrupt enable and the other bits 0;
  - address 1: reload value;
  - address 2: live count;
  - address 3: reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Source-clock strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload value) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| irq_drive | output | 1 | 1 while the open-drain pin is pulled low |
| irq_level_n | output | 1 | Pin level with pull-up: 0 when driven, 1 when released |

## Verification
The bound checker checks on every cycle:
- the pin equation against the flag and enable bits;
- that the count holds while stopped and steps down by one per tick while running;
- that a 1-to-0 tick raises the flag and reloads the count;
- that the flag never rises without an event;
- that a zero count stays zero while running.

Some behaviours show only in the bench's scenarios, where a behavioural reference model is compared every cycle. These are: the decoding of control writes (flag writes of 1 being ignored, no reload on a repeated run write), the collision of a flag clear with an event, and the readback address map.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_FLAG = 1;
  localparam int unsigned CB_IE   = 2;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             run_q,
  output logic             ie_q,
  output logic             ie_nxt,
  output logic [CNT_W-1:0] reload_q,
  output logic             start_pulse,
  output logic             flag_clr_req
);
  logic ctrl_wr;
  logic run_nxt;

  assign ctrl_wr      = wr_en && (wr_addr == SEL_CTRL);
  assign run_nxt      = ctrl_wr ? wr_data[CB_RUN] : run_q;
  assign ie_nxt       = ctrl_wr ? wr_data[CB_IE]  : ie_q;
  assign start_pulse  = ctrl_wr && wr_data[CB_RUN] && !run_q;
  assign flag_clr_req = ctrl_wr && !wr_data[CB_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      reload_q <= '0;
    end else begin
      run_q <= run_nxt;
      ie_q  <= ie_nxt;
      if (wr_en && (wr_addr == SEL_RELOAD))
        reload_q <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count_q,
  output logic             evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step = run && tick;
  assign evt  = step && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (start || evt)
      count_q <= reload;
    else if (step && (count_q != '0))
      count_q <= count_q - ONE;
  end
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr_req,
  input  logic ie_nxt,
  output logic flag_q,
  output logic drive_q
);
  logic flag_nxt;

  // an event outranks a same-cycle clear
  assign flag_nxt = evt ? 1'b1 : (clr_req ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      flag_q  <= flag_nxt;
      drive_q <= flag_nxt && ie_nxt;
    end
  end
endmodule

// File: rtl/period_irq_timer.sv
module period_irq_timer
  import period_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_drive,
  output logic             irq_level_n
);
  logic             run_q, ie_q, ie_nxt, start_pulse, flag_clr_req;
  logic             flag_q, evt;
  logic [CNT_W-1:0] reload_q, count_q;
  logic [CNT_W-1:0] ctrl_word, rd_mux;

  tmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_q(run_q), .ie_q(ie_q), .ie_nxt(ie_nxt), .reload_q(reload_q),
    .start_pulse(start_pulse), .flag_clr_req(flag_clr_req)
  );

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .start(start_pulse), .tick(tick),
    .reload(reload_q), .count_q(count_q), .evt(evt)
  );

  tmr_irq_flag u_irq (
    .clk(clk), .rst(rst), .evt(evt), .clr_req(flag_clr_req), .ie_nxt(ie_nxt),
    .flag_q(flag_q), .drive_q(irq_drive)
  );

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_RUN]  = run_q;
    ctrl_word[CB_FLAG] = flag_q;
    ctrl_word[CB_IE]   = ie_q;
    case (reg_sel_e'(rd_addr))
      SEL_CTRL:   rd_mux = ctrl_word;
      SEL_RELOAD: rd_mux = reload_q;
      SEL_COUNT:  rd_mux = count_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign irq_level_n = ~irq_drive;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic             start_pulse,
  input logic             evt,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q,
  input logic             irq_drive,
  input logic             irq_level_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!flag_q && !run_q && !ie_q && count_q == '0 && !irq_drive));

  a_r7_pin_follows: assert property (@(posedge clk) disable iff (rst)
    irq_drive == (flag_q && ie_q));

  a_r7_level_inverse: assert property (@(posedge clk) disable iff (rst)
    irq_level_n == !irq_drive);

  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_pulse) |=> count_q == $past(count_q));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && count_q > ONE) |=> count_q == $past(count_q) - ONE);

  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tick) |=> count_q == $past(count_q));

  a_r5_event_reload: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && count_q == ONE) |=> (flag_q && count_q == $past(reload_q)));

  a_r6_no_spurious_flag: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !evt) |=> !flag_q);

  a_r8_zero_stays: assert property (@(posedge clk) disable iff (rst)
    (run_q && count_q == '0) |=> count_q == '0);
endmodule

bind period_irq_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run_q(run_q), .ie_q(ie_q),
  .flag_q(flag_q), .start_pulse(start_pulse), .evt(evt), .count_q(count_q),
  .reload_q(reload_q), .irq_drive(irq_drive), .irq_level_n(irq_level_n)
);

// File: tb/sim_period_irq_timer.sv
`timescale 1ns/1ps
module sim_period_irq_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic irq_drive, irq_level_n;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  bit m_run, m_flag, m_ie;
  int m_reload, m_cnt, m_rd;

  always #4 clk = ~clk;

  period_irq_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_drive(irq_drive), .irq_level_n(irq_level_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model update on every edge, from pre-edge state
  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_flag = 0; m_ie = 0; m_reload = 0; m_cnt = 0; m_rd = 0;
    end else begin
      bit cw, st, ev;
      int ctl;
      ctl = m_run + 2 * m_flag + 4 * m_ie;
      case (rd_addr)
        2'd0: m_rd = ctl;
        2'd1: m_rd = m_reload;
        2'd2: m_rd = m_cnt;
        default: m_rd = 0;
      endcase
      cw = wr_en && wr_addr == 2'd0;
      st = cw && wr_data[0] && !m_run;
      ev = m_run && tick && m_cnt == 1;
      if (st || ev) m_cnt = m_reload;
      else if (m_run && tick && m_cnt != 0) m_cnt = m_cnt - 1;
      if (ev) m_flag = 1;
      else if (cw && !wr_data[1]) m_flag = 0;
      if (cw) begin
        m_run = wr_data[0];
        m_ie = wr_data[2];
      end
      if (wr_en && wr_addr == 2'd1) m_reload = int'(wr_data);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 pin drive vs model", int'(irq_drive), int'(m_flag && m_ie));
      chk("R7 pin level vs model", int'(irq_level_n), int'(!(m_flag && m_ie)));
      chk("R10 read data vs model", int'(rd_data), m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d); tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl after reset", v, 0);
    rd(2'd2, v); chk("R1 count after reset", v, 0);
    chk("R1 pin released", int'(irq_level_n), 1);
    // R10 readback of reload and unused address
    wr(2'd1, 3);
    rd(2'd1, v); chk("R10 reload readback", v, 3);
    rd(2'd3, v); chk("R10 unused address", v, 0);
    // R2 start loads reload value
    wr(2'd0, 5);
    rd(2'd2, v); chk("R2 load on start", v, 3);
    // R4 no tick, no change
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R4 hold without tick", v, 3);
    ticks(2);
    rd(2'd2, v); chk("R4 two ticks", v, 1);
    chk("R5 no early event", int'(irq_drive), 0);
    // R5 event
    ticks(1);
    chk("R5 pin driven on event", int'(irq_drive), 1);
    rd(2'd2, v); chk("R5 reload after event", v, 3);
    // R6 stop keeps flag, R3 hold while stopped
    wr(2'd0, 6);
    rd(2'd0, v); chk("R6 flag kept after stop", v, 6);
    ticks(5);
    rd(2'd2, v); chk("R3 count held while stopped", v, 3);
    // R7 ie toggle
    wr(2'd0, 2);
    chk("R7 released with ie 0", int'(irq_level_n), 1);
    wr(2'd0, 6);
    chk("R7 driven with ie 1", int'(irq_drive), 1);
    // R6 clear and ignored set
    wr(2'd0, 4);
    chk("R6 cleared flag releases pin", int'(irq_drive), 0);
    wr(2'd0, 6);
    rd(2'd0, v); chk("R6 writing flag 1 ignored", v, 4);
    // R8 zero reload
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd0, 5);
    ticks(10);
    rd(2'd0, v); chk("R8 no event with zero reload", v, 5);
    rd(2'd2, v); chk("R8 count stays zero", v, 0);
    // R9 collision
    wr(2'd0, 0); wr(2'd1, 2); wr(2'd0, 5);
    ticks(1);
    wr_tick(2'd0, 5);
    rd(2'd0, v); chk("R9 event beats clear", v, 7);
    rd(2'd2, v); chk("R9 reload on collision", v, 2);
    // R2 repeated run write does not reload
    ticks(1);
    wr(2'd0, 7);
    rd(2'd2, v); chk("R2 no reload while running", v, 1);
    // R5 repeat after clearing only the flag
    wr(2'd0, 5);
    chk("R5 flag cleared", int'(irq_drive), 0);
    ticks(1);
    rd(2'd0, v); chk("R5 event repeats", v, 7);
    chk("R5 pin low again", int'(irq_drive), 1);
    // R7 event with ie 0, reload 1
    wr(2'd0, 0); wr(2'd1, 1); wr(2'd0, 1);
    ticks(1);
    rd(2'd0, v); chk("R5 period of one tick", v, 3);
    chk("R7 ie 0 keeps pin released", int'(irq_drive), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule